// File: doc/BRIEF.md
# Zero-Anchored General-Purpose Register Bank

This block is the architectural register store for a small load/store core. It holds eight 32-bit registers that are addressed by 3-bit indices. Two read ports run side by side. Each is a pure combinational lookup, so an operand appears on its data pin in the same cycle that its index is applied. A single write port commits a value on the rising clock edge when its enable is high.

Index 0 is a constant zero. The read path forces zero whenever index 0 is selected, so any write aimed at it has no effect. There is no bypass from the write port to the read ports. A read in the same cycle as a write to that register returns the value held before the edge. Hazards of this kind are left to the surrounding pipeline.

All pins are plain control and data signals. Nothing here carries a stream, so there is no valid/ready handshake and no back-pressure. The storage flops have no reset. Every register except index 0 is undefined until it is first written.

Top module: `gpr_bank`

## Requirements
- R1: The bank holds 8 registers of 32 bits each. A value written to index k (k from 1 to 7) is returned by any later read of index k until k is written again, and writes to one index leave every other index unchanged.
- R2: A read of index 0 returns 32'h0000_0000 on either read port, at all times.
- R3: A write with enable high and index 0 changes nothing: index 0 still reads zero and indices 1 to 7 keep their values.
- R4: Each read port is combinational. After its index input changes, its data output shows the addressed register within the same clock cycle, with no clock edge in between.
- R5: With the write enable high at a rising clock edge, the write data is stored at the write index, and a read of that index shows the new value straight after that edge.
- R6: While a write to index k is pending in a cycle, a read of index k in that same cycle returns the value held before the edge, not the write data.
- R7: When both read ports select the same index, both return that register's value.
- R8: With the write enable low at a rising clock edge, no register changes, whatever the write index and write data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| wr_en | input | 1 | Write enable for the single write port |
| wr_idx | input | 3 | Destination register index |
| wr_data | input | 32 | Value to store |
| rd_idx_a | input | 3 | Index for read port A |
| rd_data_a | output | 32 | Combinational data for read port A |
| rd_idx_b | input | 3 | Index for read port B |
| rd_data_b | output | 32 | Combinational data for read port B |

## Verification
The properties assume the register count is a power of two, so every index value names a real register. Because the block has no reset input, the properties start being checked only after the first clock edge. They also assume that the write pins are stable around the rising edge. The bench meets these conditions in three ways:
- It changes every input on the falling edge, half a period away from the commit edge.
- It writes all seven storage registers before it compares any of them against its model.
- It draws indices from the full 3-bit range, so index 0 and repeated indices on both ports come up often.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int GPR_COUNT = 8;
  localparam int GPR_WIDTH = 32;
  localparam int GPR_IDX_W = $clog2(GPR_COUNT);
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int NUM_REGS = gpr_pkg::GPR_COUNT,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  output logic [NUM_REGS-1:0] wr_sel
);
  // Entry 0 never receives a write strobe.
  assign wr_sel[0] = 1'b0;
  for (genvar i = 1; i < NUM_REGS; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (wr_idx == IDX_W'(i));
  end
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int NUM_REGS = gpr_pkg::GPR_COUNT,
  parameter int DATA_W   = gpr_pkg::GPR_WIDTH
) (
  input  logic                             clk,
  input  logic [NUM_REGS-1:0]              wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  q
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    if (i == 0) begin : g_const
      // No flops for the constant entry; its strobe is unused.
      logic unused_sel;
      assign unused_sel = wr_sel[0];
      assign q[0] = '0;
    end else begin : g_flop
      always_ff @(posedge clk) begin
        if (wr_sel[i]) q[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int NUM_REGS = gpr_pkg::GPR_COUNT,
  parameter int DATA_W   = gpr_pkg::GPR_WIDTH,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] q,
  input  logic [IDX_W-1:0]                idx,
  output logic [DATA_W-1:0]               data
);
  always_comb begin
    if (idx == '0) data = '0;
    else           data = q[idx];
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int NUM_REGS = gpr_pkg::GPR_COUNT,
  parameter int DATA_W   = gpr_pkg::GPR_WIDTH,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam int NUM_PORTS = 2;

  logic [NUM_REGS-1:0]             wr_sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] q;
  logic [NUM_PORTS-1:0][IDX_W-1:0] rd_idx;
  logic [NUM_PORTS-1:0][DATA_W-1:0] rd_data;

  assign rd_idx[0] = rd_idx_a;
  assign rd_idx[1] = rd_idx_b;
  assign rd_data_a = rd_data[0];
  assign rd_data_b = rd_data[1];

  gpr_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .wr_en (wr_en),
    .wr_idx(wr_idx),
    .wr_sel(wr_sel)
  );

  gpr_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .q      (q)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    gpr_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
      .q   (q),
      .idx (rd_idx[p]),
      .data(rd_data[p])
    );
  end
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
  parameter int NUM_REGS = gpr_pkg::GPR_COUNT,
  parameter int DATA_W   = gpr_pkg::GPR_WIDTH,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  rd_idx_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [IDX_W-1:0]  rd_idx_b,
  input logic [DATA_W-1:0] rd_data_b
);
  // No reset pin: properties are armed after the first clock edge.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  AST_ZERO_PORT_A: assert property (@(posedge clk) disable iff (!armed)
    (rd_idx_a == '0) |-> (rd_data_a == '0)); // R2
  AST_ZERO_PORT_B: assert property (@(posedge clk) disable iff (!armed)
    (rd_idx_b == '0) |-> (rd_data_b == '0)); // R2
  AST_ZERO_AFTER_WRITE: assert property (@(posedge clk) disable iff (!armed)
    (wr_en && wr_idx == '0 && wr_data != '0) |=> (rd_idx_a != '0 || rd_data_a == '0)); // R3
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!armed)
    (wr_en && wr_idx != '0) |=> (rd_idx_a != $past(wr_idx) || rd_data_a == $past(wr_data))); // R5
  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!armed)
    (rd_idx_a == rd_idx_b) |-> (rd_data_a == rd_data_b)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!armed)
    (!wr_en) |=> (!$stable(rd_idx_b) || $stable(rd_data_b))); // R8
endmodule

bind gpr_bank gpr_bank_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
  .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
);

// File: tb/test_gpr_bank.sv
module test_gpr_bank;
  localparam int N  = 8;
  localparam int W  = 32;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [W-1:0]  wr_data = '0;
  logic [IW-1:0] rd_idx_a = '0;
  logic [IW-1:0] rd_idx_b = '0;
  logic [W-1:0]  rd_data_a, rd_data_b;

  int total = 0;
  int bad = 0;
  logic [W-1:0] model [N];

  always #10 clk = ~clk;  // 50 MHz

  gpr_bank i_gpr_bank (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
  );

  function automatic logic [W-1:0] expect_rd(input logic [IW-1:0] idx);
    return (idx == '0) ? '0 : model[idx];
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Read both ports combinationally, no clock edge between drive and sample.
  task automatic rd_pair(input logic [IW-1:0] a, input logic [IW-1:0] b, input string req);
    @(negedge clk);
    wr_en = 1'b0;
    rd_idx_a = a;
    rd_idx_b = b;
    #2;
    check({req, " port A (R4)"}, rd_data_a, expect_rd(a));
    check({req, " port B (R4)"}, rd_data_b, expect_rd(b));
  endtask

  // Drive a write; optionally check the same-cycle read returns old data.
  task automatic wr_op(input logic en, input logic [IW-1:0] idx, input logic [W-1:0] d,
                       input bit chk_old);
    @(negedge clk);
    wr_en = en;
    wr_idx = idx;
    wr_data = d;
    rd_idx_a = idx;
    #2;
    if (chk_old) check("R6 same-cycle old value", rd_data_a, expect_rd(idx));
    @(posedge clk);
    if (en && idx != '0) model[idx] = d;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) model[i] = '0;
    // Reset-state observable: index 0 reads zero before any write (R2).
    rd_pair(3'd0, 3'd0, "R2 initial zero");
    // Fill x1..x7 with 1..7 (R1, R5).
    for (int i = 1; i < N; i++) wr_op(1'b1, IW'(i), W'(i), 1'b0);
    for (int i = 0; i < N; i++) rd_pair(IW'(i), IW'(N - 1 - i), "R1 fill readback");
    // Write to x0 is dropped (R3).
    wr_op(1'b1, 3'd0, 32'd99, 1'b1);
    for (int i = 0; i < N; i++) rd_pair(IW'(i), 3'd0, "R3 x0 write dropped");
    // Same-cycle write/read returns old value, new value after edge (R6, R5).
    wr_op(1'b1, 3'd3, 32'd100, 1'b1);
    rd_pair(3'd3, 3'd3, "R5 new value after edge");
    // Enable low: nothing changes (R8).
    wr_op(1'b0, 3'd5, 32'hDEAD_BEEF, 1'b1);
    for (int i = 0; i < N; i++) rd_pair(IW'(i), IW'(i), "R8 disabled write / R7 same index");
    // All-ones at highest index (R1 boundary).
    wr_op(1'b1, 3'd7, 32'hFFFF_FFFF, 1'b1);
    rd_pair(3'd7, 3'd6, "R1 all-ones boundary");
    // Constrained random mix.
    for (int n = 0; n < 400; n++) begin
      wr_op(($urandom % 4) != 0, IW'($urandom % N), $urandom, 1'b1);
      rd_pair(IW'($urandom % N), IW'($urandom % N), "R1/R7 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule